// File: doc/BRIEF.md
# Execute-Stage ALU with Signed Condition Flags

This block is the arithmetic heart of the execute stage of a small 32-bit processor. A combinational datapath performs one of four whole-word integer operations on two operands. A three-bit flag register records whether the last flag-setting result was zero, negative, or overflowed in two's-complement terms. There is no carry flag, because integers are treated as signed throughout.

A condition evaluator reads the stored flags and a 4-bit condition code. It returns a single bit that the surrounding pipeline uses both to decide a branch and to decide whether a conditional register move happens. The flag register loads only when the caller raises the update enable. The same adder can therefore serve address arithmetic and stack-pointer adjustment without disturbing the flags.

Top module: `exec_alu_cc`

## Requirements
- R1: With operation code 0, `alu_res` equals `opnd_b + opnd_a` modulo 2^32, combinationally.
- R2: With operation code 1, `alu_res` equals `opnd_b - opnd_a` modulo 2^32, so the second operand is the minuend.
- R3: Operation code 2 gives the bitwise AND and operation code 3 gives the bitwise XOR of the two operands.
- R4: Operation codes 4 to 15 drive `alu_res` to zero and raise `op_invalid`. Codes 0 to 3 keep `op_invalid` low.
- R5: On a rising clock edge with `cc_load` high, `flag_zero` takes (result == 0) and `flag_sign` takes bit 31 of the result present before that edge.
- R6: On such a load, `flag_ovf` takes signed overflow. For code 0 that is equal operand signs with a result sign that differs. For code 1 it is different operand signs with a result sign that differs from `opnd_b`. For codes 2 and 3 and for invalid codes it is 0.
- R7: While `cc_load` is low, all three flags keep their values across clock edges, whatever the operation and operands.
- R8: A synchronous active-high `rst` sets the flags to zero=1, sign=0, overflow=0.
- R9: `cond_true` is combinational from the stored flags. With x = sign XOR overflow: code 0 gives 1, 1 gives x OR zero, 2 gives x, 3 gives zero, 4 gives NOT zero, 5 gives NOT x, and 6 gives NOT x AND NOT zero. After a subtract, codes 1 to 6 therefore mean `opnd_b` <=, <, ==, !=, >=, > `opnd_a` (signed).
- R10: Condition codes 7 to 15 give `cond_true` = 0 for every flag state.
- R11: In a cycle where `cc_load` is high, `cond_true` reflects the flags stored before the coming edge. It changes to the new flags only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flags |
| opnd_a | input | 32 | First operand (subtrahend for subtract) |
| opnd_b | input | 32 | Second operand (minuend for subtract) |
| alu_op | input | 4 | Operation code: 0 add, 1 subtract, 2 AND, 3 XOR |
| cc_load | input | 1 | Load the flag register from this cycle's result |
| cond_sel | input | 4 | Condition code 0 to 6; 7 to 15 always false |
| alu_res | output | 32 | Combinational result |
| op_invalid | output | 1 | Operation code is outside 0 to 3 |
| flag_zero | output | 1 | Stored zero flag |
| flag_sign | output | 1 | Stored sign flag |
| flag_ovf | output | 1 | Stored signed overflow flag |
| cond_true | output | 1 | Branch / conditional-move decision |

## Verification
A flag load and a condition evaluation can fall in the same cycle. This is how an arithmetic operation followed at once by a dependent branch looks to the block. The bench provokes it by first leaving the zero flag set. It then raises `cc_load` with a subtract whose result is nonzero while selecting the "equal" condition. It judges the result by requiring `cond_true` = 1 before the edge and 0 after it. Condition sweeps run after subtracts of operand pairs chosen near the signed limits, and each expected bit comes from a signed comparison of the operands rather than from the flag formulas.

// File: rtl/xalu_pkg.sv
`timescale 1ns/1ps
package xalu_pkg;

    localparam int FN_W = 4;

    typedef enum logic [FN_W-1:0] {
        ALU_ADD = 4'h0,
        ALU_SUB = 4'h1,
        ALU_AND = 4'h2,
        ALU_XOR = 4'h3
    } alu_op_e;

    typedef enum logic [FN_W-1:0] {
        CND_ALW = 4'h0,
        CND_LE  = 4'h1,
        CND_LT  = 4'h2,
        CND_EQ  = 4'h3,
        CND_NE  = 4'h4,
        CND_GE  = 4'h5,
        CND_GT  = 4'h6
    } cnd_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } ccode_t;

    localparam ccode_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

    function automatic logic op_is_valid(logic [FN_W-1:0] fn);
        return fn <= 4'(ALU_XOR);
    endfunction

    function automatic logic cond_met(ccode_t cc, logic [FN_W-1:0] fn);
        logic lt;
        logic res;
        lt = cc.sf ^ cc.of;
        case (fn)
            4'(CND_ALW): res = 1'b1;
            4'(CND_LE):  res = lt | cc.zf;
            4'(CND_LT):  res = lt;
            4'(CND_EQ):  res = cc.zf;
            4'(CND_NE):  res = ~cc.zf;
            4'(CND_GE):  res = ~lt;
            4'(CND_GT):  res = ~lt & ~cc.zf;
            default:     res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/xalu_core.sv
`timescale 1ns/1ps
module xalu_core
    import xalu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [FN_W-1:0] fn,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   res,
    output logic            bad,
    output ccode_t          cc_calc
);
    localparam int MSB = DW - 1;

    logic          is_sub;
    logic [DW-1:0] addend;
    logic [DW-1:0] sum;
    logic          sum_ovf;

    // Shared adder: subtract is b + ~a + 1
    assign is_sub  = (fn == 4'(ALU_SUB));
    assign addend  = is_sub ? ~a : a;
    assign sum     = b + addend + {{(DW-1){1'b0}}, is_sub};
    assign sum_ovf = (b[MSB] == addend[MSB]) && (sum[MSB] != b[MSB]);

    always_comb begin
        res        = '0;
        cc_calc.of = 1'b0;
        case (fn)
            4'(ALU_ADD), 4'(ALU_SUB): begin
                res        = sum;
                cc_calc.of = sum_ovf;
            end
            4'(ALU_AND): res = a & b;
            4'(ALU_XOR): res = a ^ b;
            default:     res = '0;
        endcase
        cc_calc.zf = (res == '0);
        cc_calc.sf = res[MSB];
    end

    assign bad = ~op_is_valid(fn);

endmodule

// File: rtl/xalu_ccreg.sv
`timescale 1ns/1ps
module xalu_ccreg
    import xalu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ld,
    input  ccode_t d,
    output ccode_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= CC_RESET;
        else if (ld)
            q <= d;
    end

    // R7: flags hold when no load is requested
    a_r7_hold_flags: assert property (@(posedge clk) disable iff (rst)
        !ld |=> q == $past(q));

    // R8: reset value
    a_r8_reset_value: assert property (@(posedge clk)
        rst |=> q == CC_RESET);

endmodule

// File: rtl/xalu_cond.sv
`timescale 1ns/1ps
module xalu_cond
    import xalu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  ccode_t          cc,
    input  logic [FN_W-1:0] sel,
    output logic            take
);
    assign take = cond_met(cc, sel);

    // R10: reserved condition codes never fire
    a_r10_reserved_false: assert property (@(posedge clk) disable iff (rst)
        (sel >= 4'd7) |-> !take);

    // R9: always-code is true and equal / not-equal are complementary on zero
    a_r9_always_true: assert property (@(posedge clk) disable iff (rst)
        (sel == 4'd0) |-> take);

    a_r9_ne_vs_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == 4'd4) |-> (take != cc.zf));

endmodule

// File: rtl/exec_alu_cc.sv
`timescale 1ns/1ps
module exec_alu_cc
    import xalu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   opnd_a,
    input  logic [DW-1:0]   opnd_b,
    input  logic [FN_W-1:0] alu_op,
    input  logic            cc_load,
    input  logic [FN_W-1:0] cond_sel,
    output logic [DW-1:0]   alu_res,
    output logic            op_invalid,
    output logic            flag_zero,
    output logic            flag_sign,
    output logic            flag_ovf,
    output logic            cond_true
);
    ccode_t cc_next;
    ccode_t cc_now;

    xalu_core #(.DW(DW)) u_core (
        .fn      (alu_op),
        .a       (opnd_a),
        .b       (opnd_b),
        .res     (alu_res),
        .bad     (op_invalid),
        .cc_calc (cc_next)
    );

    xalu_ccreg u_ccreg (
        .clk (clk),
        .rst (rst),
        .ld  (cc_load),
        .d   (cc_next),
        .q   (cc_now)
    );

    xalu_cond u_cond (
        .clk  (clk),
        .rst  (rst),
        .cc   (cc_now),
        .sel  (cond_sel),
        .take (cond_true)
    );

    assign flag_zero = cc_now.zf;
    assign flag_sign = cc_now.sf;
    assign flag_ovf  = cc_now.of;

    // R4: an invalid operation produces zero
    a_r4_invalid_zero: assert property (@(posedge clk) disable iff (rst)
        op_invalid |-> (alu_res == '0));

    // R5: loaded zero / sign follow the result seen at the port
    a_r5_zero_sign_load: assert property (@(posedge clk) disable iff (rst)
        cc_load |=> (flag_zero == ($past(alu_res) == '0)) &&
                    (flag_sign == $past(alu_res[DW-1])));

    // R6: logical operations clear overflow
    a_r6_logic_clears_ovf: assert property (@(posedge clk) disable iff (rst)
        (cc_load && (alu_op == 4'(ALU_AND) || alu_op == 4'(ALU_XOR))) |=> !flag_ovf);

endmodule

// File: tb/sim_exec_alu_cc.sv
`timescale 1ns/1ps
module sim_exec_alu_cc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a = '0, b = '0;
    logic [3:0]  afn = '0, cfn = '0;
    logic        we = 1'b0;
    logic [31:0] res;
    logic        bad, fz, fs, fo, ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    exec_alu_cc u0 (
        .clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .alu_op(afn),
        .cc_load(we), .cond_sel(cfn), .alu_res(res), .op_invalid(bad),
        .flag_zero(fz), .flag_sign(fs), .flag_ovf(fo), .cond_true(ok)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Independent reference: wide signed arithmetic
    task automatic model(input logic [3:0] fn, input logic [31:0] va, vb,
                         output logic [31:0] r, output logic z, s, o);
        longint sa, sb, w;
        sa = longint'($signed(va));
        sb = longint'($signed(vb));
        o  = 1'b0;
        r  = '0;
        case (fn)
            4'd0: begin w = sb + sa; r = w[31:0]; o = (w > 64'sd2147483647) || (w < -64'sd2147483648); end
            4'd1: begin w = sb - sa; r = w[31:0]; o = (w > 64'sd2147483647) || (w < -64'sd2147483648); end
            4'd2: r = va & vb;
            4'd3: r = va ^ vb;
            default: r = '0;
        endcase
        z = (r == 0);
        s = r[31];
    endtask

    function automatic logic exp_cond(int f, longint sb, longint sa);
        case (f)
            0: return 1'b1;
            1: return sb <= sa;
            2: return sb <  sa;
            3: return sb == sa;
            4: return sb != sa;
            5: return sb >= sa;
            6: return sb >  sa;
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_op(string tag, logic [3:0] fn, logic [31:0] va, logic [31:0] vb);
        logic [31:0] er;
        logic ez, es, eo;
        model(fn, va, vb, er, ez, es, eo);
        afn = fn; a = va; b = vb; we = 1'b1;
        #1;
        chk({tag, " result"}, res, er);
        chk({tag, " invalid"}, {31'd0, bad}, {31'd0, fn > 4'd3});
        step();
        we = 1'b0;
        #1;
        chk({tag, " flags zso"}, {29'd0, fz, fs, fo}, {29'd0, ez, es, eo});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        #1;
        chk("R8 reset flags", {29'd0, fz, fs, fo}, 32'd4);
        cfn = 4'd3; #1; chk("R8 reset eq true", {31'd0, ok}, 32'd1);
        cfn = 4'd6; #1; chk("R9 reset gt false", {31'd0, ok}, 32'd0);
    endtask

    task automatic t_add();
        do_op("R1 add small", 4'd0, 32'd7, 32'd5);
        do_op("R1 R6 add pos ovf", 4'd0, 32'd1, 32'h7fffffff);
        do_op("R1 R5 add wrap zero", 4'd0, 32'd1, 32'hffffffff);
        do_op("R6 add neg ovf", 4'd0, 32'h80000000, 32'h80000000);
        do_op("R1 add negative", 4'd0, 32'hfffffff0, 32'd3);
    endtask

    task automatic t_sub();
        do_op("R2 sub order", 4'd1, 32'd3, 32'd10);
        do_op("R2 sub negative", 4'd1, 32'd10, 32'd3);
        do_op("R2 R6 sub ovf", 4'd1, 32'd1, 32'h80000000);
        do_op("R6 sub pos ovf", 4'd1, 32'h80000000, 32'd0);
        do_op("R2 R5 sub equal", 4'd1, 32'h12345678, 32'h12345678);
    endtask

    task automatic t_logic();
        do_op("R6 prep ovf", 4'd0, 32'd1, 32'h7fffffff);
        do_op("R3 R6 and clears ovf", 4'd2, 32'hf0f0ff00, 32'h8f0f0ff0);
        do_op("R3 xor", 4'd3, 32'h0000ffff, 32'h12345678);
        do_op("R3 R5 xor self zero", 4'd3, 32'hdeadbeef, 32'hdeadbeef);
    endtask

    task automatic t_invalid();
        do_op("R6 prep ovf2", 4'd0, 32'd1, 32'h7fffffff);
        do_op("R4 op 4", 4'd4, 32'h11111111, 32'h22222222);
        do_op("R4 op 9", 4'd9, 32'hffffffff, 32'h00000001);
        do_op("R4 op 15", 4'd15, 32'h80000000, 32'h80000000);
    endtask

    task automatic t_hold();
        do_op("R7 prep", 4'd1, 32'd2, 32'd1);   // negative, no overflow
        cfn = 4'd2;
        afn = 4'd0; a = 32'd1; b = 32'h7fffffff; we = 1'b0;
        step(); step();
        afn = 4'd1; a = 32'd5; b = 32'd5;
        step();
        #1;
        chk("R7 flags held", {29'd0, fz, fs, fo}, 32'd2);
        chk("R7 cond held", {31'd0, ok}, 32'd1);
    endtask

    task automatic t_cond_sweep(string tag, logic [31:0] va, logic [31:0] vb);
        do_op({tag, " sub"}, 4'd1, va, vb);
        for (int f = 0; f < 16; f++) begin
            cfn = 4'(f);
            #1;
            chk($sformatf("%s cond %0d", tag, f), {31'd0, ok},
                {31'd0, exp_cond(f, longint'($signed(vb)), longint'($signed(va)))});
        end
    endtask

    task automatic t_same_cycle();
        do_op("R11 prep equal", 4'd1, 32'd5, 32'd5);
        cfn = 4'd3;
        afn = 4'd1; a = 32'd1; b = 32'd5; we = 1'b1;
        #1;
        chk("R11 cond uses old flags", {31'd0, ok}, 32'd1);
        step();
        we = 1'b0;
        #1;
        chk("R11 cond after edge", {31'd0, ok}, 32'd0);
        chk("R11 zero after edge", {31'd0, fz}, 32'd0);
    endtask

    task automatic t_reset_mid();
        do_op("R8 prep", 4'd1, 32'd1, 32'h80000000);
        rst = 1'b1;
        step();
        rst = 1'b0;
        #1;
        chk("R8 mid-run reset", {29'd0, fz, fs, fo}, 32'd4);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #2;
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_invalid();
        t_hold();
        t_cond_sweep("R9 R10 lt", 32'd9, 32'd4);
        t_cond_sweep("R9 R10 gt", 32'd4, 32'd9);
        t_cond_sweep("R9 R10 eq", 32'h80000000, 32'h80000000);
        t_cond_sweep("R9 R10 ovf lt", 32'd1, 32'h80000000);
        t_cond_sweep("R9 R10 ovf gt", 32'h80000000, 32'h7fffffff);
        t_cond_sweep("R9 R10 neg", 32'hfffffffe, 32'hffffffff);
        t_same_cycle();
        t_reset_mid();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule